// File: doc/BRIEF.md
# Write Inhibit and Glitch Guard

This block stands in front of a nonvolatile memory's write engine and decides whether a falling write strobe may start a write. It combines three filters. A power-on lockout holds writes off while the digitised supply-good flag is low and for a fixed number of clock cycles after that flag rises. A static decode of the chip-enable, output-enable and write-enable strobes blocks writes unless the three strobes are in the one write combination. A minimum-width filter ignores strobe-low periods that are too short to be real write cycles.

All inputs are taken to be synchronous to `clk`, with any synchronisation done upstream. The output is a single-cycle `wr_start` pulse for the write engine and a plain `lockout` level. Neither is a data stream, so the block has no valid/ready handshake and no back-pressure. The lockout length and the minimum width are parameters counted in clock cycles.

Top module: `wr_guard`

## Requirements
- R1: After reset `wr_start` is 0 and `lockout` is 1.
- R2: While `pwr_good` is 0, `lockout` is 1 from the next clock edge, and no `wr_start` is produced whatever the strobes do.
- R3: With `pwr_good` held at 1, `lockout` stays 1 through the first LOCK_CYC-1 rising edges and falls after the LOCK_CYC-th edge.
- R4: A single-cycle drop of `pwr_good` during or after the lockout restarts the lockout count from zero.
- R5: Writes are blocked when `oe_n`=0, when `cs_n`=1 or when `we_n`=1. Any one of these on its own is enough.
- R6: A write qualifies when `cs_n`=0, `oe_n`=1 and `we_n`=0 while no lockout is in force. If it stays qualified for MIN_W consecutive edges, `wr_start` is 1 for exactly one cycle, after the MIN_W-th edge.
- R7: A qualifying period shorter than MIN_W edges gives no `wr_start`. This holds whether the short low pulse is on `we_n` or on `cs_n`.
- R8: Only one `wr_start` is produced for each qualifying period. A second write needs the qualification to lapse first.
- R9: If the qualification lapses for even one edge, the width count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Digitised supply-above-threshold flag |
| cs_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wr_start | output | 1 | One-cycle write start pulse |
| lockout | output | 1 | Power-on lockout in force |

## Verification
A lockout counter with the wrong value shows directly on `lockout`. Its fall edge moves earlier or later by the size of the error. A missed restart shows on the first edge after a supply drop, as `lockout` staying 0. A width counter that is off by one moves the `wr_start` pulse by a cycle, or lets a pulse of MIN_W-1 edges through. An arming flag that is stuck shows up as a second pulse within one long strobe, or as no pulse on the next strobe. All of these appear within MIN_W+1 cycles of the strobe falling.

// File: rtl/wr_guard_pkg.sv
package wr_guard_pkg;
  typedef struct packed {
    logic cs_n;
    logic oe_n;
    logic we_n;
  } strobe_t;

  function automatic logic strobes_write(input strobe_t s);
    return (!s.cs_n) && s.oe_n && (!s.we_n);
  endfunction
endpackage

// File: rtl/wr_guard_lockout.sv
module wr_guard_lockout #(
  parameter int LOCK_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic lockout_o
);
  localparam int CW = (LOCK_CYC < 1) ? 1 : $clog2(LOCK_CYC + 1);

  generate
    if (LOCK_CYC == 0) begin : g_nodelay
      logic held;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held <= 1'b1;
        else        held <= !pwr_good;
      end
      assign lockout_o = held;
    end else begin : g_timer
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (!pwr_good)          cnt <= '0;
        else if (cnt < CW'(LOCK_CYC)) cnt <= cnt + 1'b1;
      end
      assign lockout_o = (cnt < CW'(LOCK_CYC));
    end
  endgenerate

  // R2
  supply_low_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> lockout_o);
  // R3
  release_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lockout_o) |-> $past(pwr_good));
endmodule

// File: rtl/wr_guard_filter.sv
module wr_guard_filter #(
  parameter int MIN_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qual,
  output logic pulse_o
);
  localparam int WW = (MIN_W < 2) ? 1 : $clog2(MIN_W + 1);

  logic [WW-1:0] wcnt;
  logic          fired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt    <= '0;
      fired   <= 1'b0;
      pulse_o <= 1'b0;
    end else if (!qual) begin
      wcnt    <= '0;
      fired   <= 1'b0;
      pulse_o <= 1'b0;
    end else if (!fired) begin
      if (wcnt == WW'(MIN_W - 1)) begin
        fired   <= 1'b1;
        pulse_o <= 1'b1;
      end else begin
        wcnt    <= wcnt + 1'b1;
        pulse_o <= 1'b0;
      end
    end else begin
      pulse_o <= 1'b0;
    end
  end

  // R6
  single_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
  // R8
  one_per_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && qual) |=> !pulse_o);
endmodule

// File: rtl/wr_guard.sv
module wr_guard
  import wr_guard_pkg::*;
#(
  parameter int LOCK_CYC = 500000,
  parameter int MIN_W    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic cs_n,
  input  logic oe_n,
  input  logic we_n,
  output logic wr_start,
  output logic lockout
);
  strobe_t strb;
  logic    qual;

  assign strb = '{cs_n: cs_n, oe_n: oe_n, we_n: we_n};
  assign qual = strobes_write(strb) && pwr_good && !lockout;

  wr_guard_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .lockout_o(lockout)
  );

  wr_guard_filter #(.MIN_W(MIN_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .qual(qual), .pulse_o(wr_start)
  );

  // R5
  decode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> $past(!cs_n && oe_n && !we_n && pwr_good));
  // R2
  no_write_in_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> !$past(lockout));
endmodule

// File: tb/sim_wr_guard.sv
module sim_wr_guard;
  localparam int LOCK = 20;
  localparam int MINW = 3;

  logic clk = 1'b0, rst_n = 1'b0, pwr_good = 1'b1;
  logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic wr_start, lockout;
  int   errors = 0, checks = 0, cyc = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  wr_guard #(.LOCK_CYC(LOCK), .MIN_W(MINW)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cs_n(cs_n),
    .oe_n(oe_n), .we_n(we_n), .wr_start(wr_start), .lockout(lockout)
  );

  // fields: cs_n oe_n we_n, hold cycles, expected pulses, requirement
  typedef struct packed { logic c, o, w; int hold; int exp; int req; } vec_t;
  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b1, 1'b0, 3,  1, 6},  // R6 exact width
    '{1'b0, 1'b1, 1'b0, 10, 1, 8},  // R8 long strobe one pulse
    '{1'b0, 1'b1, 1'b0, 2,  0, 7},  // R7 short
    '{1'b0, 1'b1, 1'b0, 1,  0, 7},  // R7 shorter
    '{1'b0, 1'b0, 1'b0, 8,  0, 5},  // R5 oe_n low
    '{1'b1, 1'b1, 1'b0, 8,  0, 5},  // R5 cs_n high
    '{1'b0, 1'b1, 1'b1, 8,  0, 5},  // R5 we_n high
    '{1'b0, 1'b1, 1'b0, 4,  1, 6}   // R6 longer than width
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic idle(); cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; endtask

  // drive strobes for hold cycles, release, count pulses seen
  task automatic burst(input logic c, o, w, input int hold, output int n);
    n = 0;
    cs_n = c; oe_n = o; we_n = w;
    for (int i = 0; i < hold; i++) begin step(); n += int'(wr_start); end
    idle();
    for (int i = 0; i < 3; i++) begin step(); n += int'(wr_start); end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) step();
    // R1 reset state
    check("R1 wr_start", int'(wr_start), 0);
    check("R1 lockout", int'(lockout), 1);
    rst_n = 1'b1;
    // R3 lockout length
    for (int i = 1; i <= LOCK; i++) begin
      step();
      if (i == LOCK - 1) check("R3 still locked", int'(lockout), 1);
      if (i == LOCK)     check("R3 released", int'(lockout), 0);
    end
    // vector table
    foreach (VECS[k]) begin
      burst(VECS[k].c, VECS[k].o, VECS[k].w, VECS[k].hold, n);
      check($sformatf("R%0d vec%0d pulses", VECS[k].req, k), n, VECS[k].exp);
    end
    // R6 exact timing
    cs_n = 1'b0; we_n = 1'b0;
    for (int i = 1; i <= MINW + 1; i++) begin
      step();
      if (i == MINW - 1) check("R6 not yet", int'(wr_start), 0);
      if (i == MINW)     check("R6 fires", int'(wr_start), 1);
      if (i == MINW + 1) check("R6 one wide", int'(wr_start), 0);
    end
    idle(); step();
    // R7 short chip-enable pulse with we_n held low
    we_n = 1'b0; step();
    cs_n = 1'b0; step(); step();
    cs_n = 1'b1; n = 0;
    for (int i = 0; i < 4; i++) begin step(); n += int'(wr_start); end
    check("R7 short cs_n", n, 0);
    idle();
    // R9 interrupted run
    n = 0;
    cs_n = 1'b0; we_n = 1'b0; step(); n += int'(wr_start); step(); n += int'(wr_start);
    we_n = 1'b1; step(); n += int'(wr_start);
    we_n = 1'b0; step(); n += int'(wr_start); step(); n += int'(wr_start);
    idle();
    for (int i = 0; i < 3; i++) begin step(); n += int'(wr_start); end
    check("R9 restart count", n, 0);
    // R8 rearm after release
    burst(1'b0, 1'b1, 1'b0, 5, n);
    check("R8 first", n, 1);
    burst(1'b0, 1'b1, 1'b0, 5, n);
    check("R8 second", n, 1);
    // R2 supply low blocks
    pwr_good = 1'b0; step();
    check("R2 lockout", int'(lockout), 1);
    burst(1'b0, 1'b1, 1'b0, 6, n);
    check("R2 no write", n, 0);
    pwr_good = 1'b1;
    // R4 drop mid-lockout restarts
    repeat (10) step();
    pwr_good = 1'b0; step(); pwr_good = 1'b1;
    for (int i = 1; i <= LOCK; i++) begin
      step();
      if (i == LOCK - 1) check("R4 restarted", int'(lockout), 1);
      if (i == LOCK)     check("R4 released", int'(lockout), 0);
    end
    burst(1'b0, 1'b1, 1'b0, 4, n);
    check("R4 write after release", n, 1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule